// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch status of every hardware thread of a multithreaded instruction front end and moves each thread between its states once per cycle. Each cycle it merges the following into one next-state decision per thread, ranked by a fixed priority:

- stall requests from four downstream stages;
- flush requests from the retire and decode stages;
- a context-switch hold;
- progress events of an instruction-line fetch: line request, translation outcome, send rejection, retry, returned line and consumption.

The block also owns one shared retry slot for a rejected cache send and a per-thread request tag. The tag lets a returned line be recognised as current or stale. The surrounding fetch datapath reads the per-thread status to decide what to fetch. It reads the stage-active flag to know whether the fetch stage has any work at all.

Top module: `fetch_status_ctl`

## Requirements
- R1: After reset every thread is Running (code 0), all stall records are clear, every request tag is 0, the cache-blocked flag is 0 and no thread holds the retry slot. State codes are: Running 0, Idle 1, Squashing 2, Blocked 3, TrapPending 4, QuiescePending 5, ItlbWait 6, IcacheWaitResponse 7, IcacheWaitRetry 8, IcacheAccessComplete 9. Thread t's code sits at `thr_state[4t+3:4t]`.
- R2: Each thread keeps four sticky stall bits, one per downstream stage. Stage s of thread t uses bit 4t+s, with decode=0, rename=1, execute=2, retire=3. A block pulse sets the bit and an unblock pulse clears it. A thread with any bit set moves to Blocked on the next cycle and stays there. Once all its bits are clear it returns to Running. Unblocking a bit that is not set is forbidden.
- R3: A context-switch hold also moves a thread to Blocked. Neither a hold nor a stall bit disturbs a thread in IcacheWaitResponse or IcacheWaitRetry.
- R4: A retire-stage squash outranks every other condition and moves the thread to Squashing. It releases the retry slot if that thread holds it; the cache-blocked flag stays set until a retry event. While ROB squashing is reported the thread stays in Squashing. In the first cycle without a squash or block condition it returns to Running.
- R5: A decode squash moves a thread to Squashing only if the thread is not already in Squashing. A decode squash that meets a Squashing thread has no effect, so the thread returns to Running.
- R6: A line request on a Running thread moves it to ItlbWait and increments that thread's request tag by one. In ItlbWait the translation outcome decides the next state:
  - a fault gives TrapPending;
  - a success with an accepted send gives IcacheWaitResponse;
  - a success with a rejected send gives IcacheWaitRetry, takes the retry slot and sets the cache-blocked flag.
- R7: A retry event clears the cache-blocked flag. If a thread holds the retry slot, that thread moves to IcacheWaitResponse and the slot is freed. At most one thread is ever in IcacheWaitRetry.
- R8: A returned line is accepted only if its thread is in IcacheWaitResponse, its tag equals that thread's current request tag and no squash hits that thread in the same cycle.
  - An accepted line moves the thread to IcacheAccessComplete, or to Blocked if the thread is stalled.
  - Any other returned line raises `stale_resp` in that cycle and changes no state.
  - A take event moves a thread from IcacheAccessComplete to Running.
- R9: A quiesce event on a Running thread moves it to QuiescePending, where it stays until a squash.
- R10: `stage_active` is 1 exactly when some thread enabled in `active_thr` is in Running, Squashing or IcacheAccessComplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stage_blk | input | 4*NTHR | Block pulses, bit 4t+s for stage s of thread t |
| stage_unblk | input | 4*NTHR | Unblock pulses, same bit layout |
| ctx_switch | input | 1 | Context-switch hold, stalls all threads |
| cmt_squash | input | NTHR | Squash from the retire stage, per thread |
| rob_squashing | input | NTHR | Retire stage still squashing, per thread |
| dec_squash | input | NTHR | Squash from the decode stage, per thread |
| line_req | input | NTHR | Start a new instruction-line request |
| xlat_done | input | NTHR | Address translation finished |
| xlat_fault | input | NTHR | Translation finished with a fault |
| send_rej | input | NTHR | Cache send rejected (with a successful translation) |
| retry_ok | input | 1 | Cache retry succeeded |
| resp_valid | input | 1 | Returned line present |
| resp_tid | input | TW | Thread of the returned line |
| resp_tag | input | TAGW | Request tag of the returned line |
| fetch_take | input | NTHR | Fetched line consumed |
| quiesce | input | NTHR | Quiesce instruction seen |
| active_thr | input | NTHR | Threads that count toward stage activity |
| thr_state | output | 4*NTHR | Per-thread state code |
| req_tag | output | TAGW*NTHR | Per-thread current request tag |
| cache_blocked | output | 1 | Cache refused a send and no retry has come yet |
| stale_resp | output | 1 | Returned line dropped this cycle |
| stage_active | output | 1 | Fetch stage has work |

## Verification
A returned line and a retire-stage squash can hit the same thread in the same cycle. The bench provokes this by first taking a thread to IcacheWaitResponse with a known tag. It then presents a correctly tagged line together with the squash. The line must be reported stale in that cycle, and the thread must be in Squashing afterwards rather than IcacheAccessComplete. A second overlap, a squash arriving with a block pulse, is judged by the thread reaching Squashing first and Blocked one cycle later.

// File: rtl/fetch_status_ctl.sv
module fetch_status_ctl #(
  parameter int NTHR = 2,
  parameter int TAGW = 4,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [4*NTHR-1:0]    stage_blk,
  input  logic [4*NTHR-1:0]    stage_unblk,
  input  logic                 ctx_switch,
  input  logic [NTHR-1:0]      cmt_squash,
  input  logic [NTHR-1:0]      rob_squashing,
  input  logic [NTHR-1:0]      dec_squash,
  input  logic [NTHR-1:0]      line_req,
  input  logic [NTHR-1:0]      xlat_done,
  input  logic [NTHR-1:0]      xlat_fault,
  input  logic [NTHR-1:0]      send_rej,
  input  logic                 retry_ok,
  input  logic                 resp_valid,
  input  logic [TW-1:0]        resp_tid,
  input  logic [TAGW-1:0]      resp_tag,
  input  logic [NTHR-1:0]      fetch_take,
  input  logic [NTHR-1:0]      quiesce,
  input  logic [NTHR-1:0]      active_thr,
  output logic [4*NTHR-1:0]    thr_state,
  output logic [TAGW*NTHR-1:0] req_tag,
  output logic                 cache_blocked,
  output logic                 stale_resp,
  output logic                 stage_active
);

  localparam logic [3:0] S_RUN  = 4'd0;
  localparam logic [3:0] S_SQ   = 4'd2;
  localparam logic [3:0] S_BLK  = 4'd3;
  localparam logic [3:0] S_TRAP = 4'd4;
  localparam logic [3:0] S_QP   = 4'd5;
  localparam logic [3:0] S_TLB  = 4'd6;
  localparam logic [3:0] S_WRSP = 4'd7;
  localparam logic [3:0] S_WRTY = 4'd8;
  localparam logic [3:0] S_CPL  = 4'd9;

  logic [3:0]          st_q [NTHR];
  logic [3:0]          st_n [NTHR];
  logic [4*NTHR-1:0]   stall_q, stall_n;
  logic [TAGW-1:0]     tag_q [NTHR];
  logic [NTHR-1:0]     pre, stl, hit, grab;
  logic [TW-1:0]       grab_tid;
  logic                slot_vld, blk_q;
  logic [TW-1:0]       slot_tid;

  always_comb begin
    stall_n  = (stall_q | stage_blk) & ~stage_unblk;
    grab     = '0;
    grab_tid = '0;
    for (int t = 0; t < NTHR; t++) begin
      stl[t] = (|stall_n[4*t +: 4]) | ctx_switch;
      pre[t] = cmt_squash[t] | rob_squashing[t] | (dec_squash[t] & (st_q[t] != S_SQ));
      hit[t] = resp_valid && (resp_tid == TW'(t)) && (st_q[t] == S_WRSP) &&
               (resp_tag == tag_q[t]) && !pre[t];
      st_n[t] = st_q[t];
      if (pre[t]) st_n[t] = S_SQ;
      else if (stl[t] && st_q[t] != S_WRSP && st_q[t] != S_WRTY) st_n[t] = S_BLK;
      else if (st_q[t] == S_BLK || st_q[t] == S_SQ) st_n[t] = S_RUN;
      else begin
        case (st_q[t])
          S_RUN:  if (quiesce[t]) st_n[t] = S_QP;
                  else if (line_req[t]) st_n[t] = S_TLB;
          S_TLB:  if (xlat_done[t])
                    st_n[t] = xlat_fault[t] ? S_TRAP : (send_rej[t] ? S_WRTY : S_WRSP);
          S_WRTY: if (retry_ok && slot_vld && slot_tid == TW'(t)) st_n[t] = S_WRSP;
          S_WRSP: if (hit[t]) st_n[t] = stl[t] ? S_BLK : S_CPL;
          S_CPL:  if (fetch_take[t]) st_n[t] = S_RUN;
          default: ;
        endcase
      end
      grab[t] = (st_q[t] == S_TLB) && (st_n[t] == S_WRTY);
      if (grab[t]) grab_tid = TW'(t);
    end
  end

  assign stale_resp    = resp_valid & ~(|hit);
  assign cache_blocked = blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_q  <= '0;
      slot_vld <= 1'b0;
      slot_tid <= '0;
      blk_q    <= 1'b0;
      for (int t = 0; t < NTHR; t++) begin
        st_q[t]  <= S_RUN;
        tag_q[t] <= '0;
      end
    end else begin
      stall_q <= stall_n;
      for (int t = 0; t < NTHR; t++) begin
        st_q[t] <= st_n[t];
        if (st_n[t] == S_TLB && st_q[t] != S_TLB) tag_q[t] <= tag_q[t] + TAGW'(1);
      end
      if (retry_ok) begin
        slot_vld <= 1'b0;
        blk_q    <= 1'b0;
      end else if (slot_vld && pre[slot_tid]) begin
        slot_vld <= 1'b0;
      end
      if (|grab) begin
        slot_vld <= 1'b1;
        slot_tid <= grab_tid;
        blk_q    <= 1'b1;
      end
    end
  end

  always_comb begin
    stage_active = 1'b0;
    for (int t = 0; t < NTHR; t++)
      if (active_thr[t] && (st_q[t] == S_RUN || st_q[t] == S_SQ || st_q[t] == S_CPL))
        stage_active = 1'b1;
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_out
    assign thr_state[4*g +: 4]    = st_q[g];
    assign req_tag[TAGW*g +: TAGW] = tag_q[g];
  end

endmodule

module fetch_status_ctl_chk #(
  parameter int NTHR = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4*NTHR-1:0] stage_unblk,
  input logic [4*NTHR-1:0] stall_q,
  input logic [NTHR-1:0]   cmt_squash,
  input logic [4*NTHR-1:0] thr_state,
  input logic              cache_blocked,
  input logic              retry_ok,
  input logic              stage_active,
  input logic [NTHR-1:0]   active_thr
);

  logic [NTHR-1:0] in_retry;
  always_comb
    for (int t = 0; t < NTHR; t++) in_retry[t] = (thr_state[4*t +: 4] == 4'd8);

  assert_unblock_only_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_unblk & ~stall_q) == '0);

  assert_single_retry_holder_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_retry));

  assert_retry_unblocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retry_ok |=> !cache_blocked);

  assert_block_needs_retry_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cache_blocked) |-> (in_retry != '0));

  assert_active_needs_thread_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stage_active |-> (active_thr != '0));

  for (genvar g = 0; g < NTHR; g++) begin : g_sq
    assert_squash_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_squash[g] |=> (thr_state[4*g +: 4] == 4'd2));
  end

endmodule

bind fetch_status_ctl fetch_status_ctl_chk #(.NTHR(NTHR)) u_chk (
  .clk(clk), .rst_n(rst_n), .stage_unblk(stage_unblk), .stall_q(stall_q),
  .cmt_squash(cmt_squash), .thr_state(thr_state), .cache_blocked(cache_blocked),
  .retry_ok(retry_ok), .stage_active(stage_active), .active_thr(active_thr)
);

// File: tb/fetch_status_ctl_test.sv
module fetch_status_ctl_test;
  localparam int NTHR = 2;
  localparam int TAGW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4*NTHR-1:0] stage_blk = '0, stage_unblk = '0;
  logic ctx_switch = 1'b0;
  logic [NTHR-1:0] cmt_squash = '0, rob_squashing = '0, dec_squash = '0;
  logic [NTHR-1:0] line_req = '0, xlat_done = '0, xlat_fault = '0, send_rej = '0;
  logic retry_ok = 1'b0, resp_valid = 1'b0;
  logic [0:0] resp_tid = '0;
  logic [TAGW-1:0] resp_tag = '0;
  logic [NTHR-1:0] fetch_take = '0, quiesce = '0;
  logic [NTHR-1:0] active_thr = '1;
  logic [4*NTHR-1:0] thr_state;
  logic [TAGW*NTHR-1:0] req_tag;
  logic cache_blocked, stale_resp, stage_active;

  int nchk = 0;
  int nerr = 0;
  int tag0 = 0;

  always #2 clk = ~clk;

  fetch_status_ctl #(.NTHR(NTHR), .TAGW(TAGW)) uut (.*);

  task automatic ck(input string r, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int st(input int t);
    return int'(thr_state[4*t +: 4]);
  endfunction

  task automatic go();
    @(negedge clk);
    stage_blk = '0; stage_unblk = '0; ctx_switch = 0; cmt_squash = '0;
    rob_squashing = '0; dec_squash = '0; line_req = '0; xlat_done = '0;
    xlat_fault = '0; send_rej = '0; retry_ok = 0; resp_valid = 0;
    fetch_take = '0; quiesce = '0;
  endtask

  task automatic to_wait_resp();
    line_req[0] = 1; go(); tag0++;
    ck("R6 line request", st(0), 6);
    ck("R6 tag increment", int'(req_tag[TAGW-1:0]), tag0);
    xlat_done[0] = 1; go();
    ck("R6 accepted send", st(0), 7);
  endtask

  task automatic t_reset();
    ck("R1 thread0 running", st(0), 0);
    ck("R1 thread1 running", st(1), 0);
    ck("R1 tags zero", int'(req_tag), 0);
    ck("R1 cache not blocked", int'(cache_blocked), 0);
    ck("R10 active after reset", int'(stage_active), 1);
  endtask

  task automatic t_stall();
    stage_blk[1] = 1; go();
    ck("R2 block rename", st(0), 3);
    ck("R2 other thread unaffected", st(1), 0);
    go(); go();
    ck("R2 block is sticky", st(0), 3);
    stage_unblk[1] = 1; go();
    ck("R2 unblock returns", st(0), 0);
    ctx_switch = 1; go();
    ck("R3 context switch blocks", st(0), 3);
    ck("R3 context switch blocks t1", st(1), 3);
    go();
    ck("R3 release after switch", st(0), 0);
  endtask

  task automatic t_miss();
    to_wait_resp();
    resp_valid = 1; resp_tid = 0; resp_tag = TAGW'(tag0 + 1); #1;
    ck("R8 wrong tag stale", int'(stale_resp), 1);
    go();
    ck("R8 wrong tag no change", st(0), 7);
    resp_valid = 1; resp_tid = 1; resp_tag = 0; #1;
    ck("R8 wrong thread stale", int'(stale_resp), 1);
    go();
    ck("R8 thread1 unchanged", st(1), 0);
    resp_valid = 1; resp_tid = 0; resp_tag = TAGW'(tag0); #1;
    ck("R8 match not stale", int'(stale_resp), 0);
    go();
    ck("R8 complete", st(0), 9);
    fetch_take[0] = 1; go();
    ck("R8 take to running", st(0), 0);
  endtask

  task automatic t_stall_in_wait();
    to_wait_resp();
    stage_blk[2] = 1; go();
    ck("R3 stall ignored in wait response", st(0), 7);
    ctx_switch = 1; go();
    ck("R3 switch ignored in wait response", st(0), 7);
    resp_valid = 1; resp_tid = 0; resp_tag = TAGW'(tag0); go();
    ck("R8 accepted while stalled", st(0), 3);
    stage_unblk[2] = 1; go();
    ck("R2 unblock after line", st(0), 0);
  endtask

  task automatic t_retry();
    line_req[0] = 1; go(); tag0++;
    xlat_done[0] = 1; send_rej[0] = 1; go();
    ck("R6 rejected send", st(0), 8);
    ck("R6 cache blocked", int'(cache_blocked), 1);
    ctx_switch = 1; go();
    ck("R3 switch ignored in wait retry", st(0), 8);
    retry_ok = 1; go();
    ck("R7 retry to wait response", st(0), 7);
    ck("R7 cache unblocked", int'(cache_blocked), 0);
    resp_valid = 1; resp_tid = 0; resp_tag = TAGW'(tag0); go();
    fetch_take[0] = 1; go();
    ck("R8 back to running", st(0), 0);
  endtask

  task automatic t_fault();
    line_req[0] = 1; go(); tag0++;
    xlat_done[0] = 1; xlat_fault[0] = 1; go();
    ck("R6 fault to trap", st(0), 4);
    ck("R10 active from thread1", int'(stage_active), 1);
    cmt_squash[0] = 1; go();
    ck("R4 squash leaves trap", st(0), 2);
    go();
    ck("R4 squash ends", st(0), 0);
  endtask

  task automatic t_squash_retry();
    line_req[0] = 1; go(); tag0++;
    xlat_done[0] = 1; send_rej[0] = 1; go();
    cmt_squash[0] = 1; rob_squashing[0] = 1; go();
    ck("R4 squash over retry wait", st(0), 2);
    rob_squashing[0] = 1; go();
    ck("R4 rob squashing holds", st(0), 2);
    go();
    ck("R4 back to running", st(0), 0);
    ck("R4 cache still blocked", int'(cache_blocked), 1);
    retry_ok = 1; go();
    ck("R7 empty retry clears block", int'(cache_blocked), 0);
    ck("R7 empty retry no state change", st(0), 0);
  endtask

  task automatic t_decode();
    dec_squash[0] = 1; go();
    ck("R5 decode squash", st(0), 2);
    dec_squash[0] = 1; go();
    ck("R5 repeated decode squash ignored", st(0), 0);
  endtask

  task automatic t_collide();
    to_wait_resp();
    resp_valid = 1; resp_tid = 0; resp_tag = TAGW'(tag0); cmt_squash[0] = 1; #1;
    ck("R8 line with squash is stale", int'(stale_resp), 1);
    go();
    ck("R4 squash beats line", st(0), 2);
    go();
    cmt_squash[0] = 1; stage_blk[0] = 1; go();
    ck("R4 squash beats block", st(0), 2);
    go();
    ck("R2 block after squash", st(0), 3);
    stage_unblk[0] = 1; go();
    ck("R2 running again", st(0), 0);
  endtask

  task automatic t_quiesce();
    quiesce[0] = 1; go();
    ck("R9 quiesce", st(0), 5);
    active_thr = 2'b01; #1;
    ck("R10 inactive when only quiesced thread", int'(stage_active), 0);
    active_thr = 2'b11; #1;
    ck("R10 active with thread1", int'(stage_active), 1);
    go();
    ck("R9 quiesce holds", st(0), 5);
    cmt_squash[0] = 1; go(); go();
    ck("R9 squash wakes", st(0), 0);
    ck("R6 thread1 tag untouched", int'(req_tag[2*TAGW-1:TAGW]), 0);
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    go(); go(); go();
    rst_n = 1;
    go();
    t_reset();
    t_stall();
    t_miss();
    t_stall_in_wait();
    t_retry();
    t_fault();
    t_squash_retry();
    t_decode();
    t_collide();
    t_quiesce();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule